// File: doc/BRIEF.md
# Scaled saturating pack unit

This datapath turns wide signed fixed-point SIMD lanes into narrow packed results. Every lane is sign-extended, shifted left by a programmable scale, shifted arithmetically right by a mode-dependent constant and then clamped to the range of its target field. The scale comes from a 64-bit graphics status word that is supplied alongside the operands. There are three conversions. The first packs four 16-bit lanes into four unsigned bytes. The second packs two 32-bit lanes into unsigned bytes and merges them with a shifted copy of a second operand. The third packs two 32-bit lanes into signed 16-bit fixed values.

Each operation is presented for one cycle with `in_valid`. The registered result appears on the next clock edge, qualified by `out_valid`. The modes that produce a 32-bit value drive the upper half of the output to zero.

Top module: `pack_sat_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the next state has `out_valid` = 0 and `result` = 0.
- R2: `out_valid` is 1 exactly in the cycle after a cycle with `in_valid` = 1 (outside reset), and 0 otherwise.
- R3: Mode 2'b00 (byte pack) takes its scale from `status[6:3]`, a value from 0 to 15, and ignores `status[7]`. Each signed 16-bit lane i of `opb` (lane 0 = bits [15:0]) is shifted left by the scale and then arithmetically right by 7.
- R4: In mode 2'b00 each lane value is clamped to 0..255 and placed in `result[8*i+7:8*i]`. `result[63:32]` is 0.
- R5: Mode 2'b01 (merge pack) takes its scale from `status[7:3]`, a value from 0 to 31. Each signed 32-bit lane w of `opb` is shifted left by the scale, then arithmetically right by 23, and clamped to 0..255.
- R6: In mode 2'b01, `result` equals `opa` shifted left by 8 with bits [7:0] and [39:32] cleared, and the clamped byte of lane w is then placed in bits [32*w+7:32*w].
- R7: Mode 2'b10 (fixed pack) uses the 5-bit scale `status[7:3]`. Each signed 32-bit lane w of `opb` is shifted left by the scale, then arithmetically right by 16, and clamped to -32768..32767. Lane 0 goes to `result[15:0]`, lane 1 to `result[31:16]`, and `result[63:32]` is 0.
- R8: The shifts are done at 64-bit signed width, so a scale of 31 applied to an extreme 32-bit lane saturates to the correct bound and never wraps.
- R9: Mode 2'b11 is reserved and yields `result` = 0.
- R10: After a cycle with `in_valid` = 0, `result` keeps its previous value whatever the data, status and mode inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| mode | input | 2 | Conversion select (00 byte, 01 merge, 10 fixed, 11 reserved) |
| status | input | 64 | Graphics status word; bits [7:3] hold the scale |
| opa | input | 64 | Merge operand (mode 01 only) |
| opb | input | 64 | Lanes to be converted |
| out_valid | output | 1 | Result qualifier, one cycle after `in_valid` |
| result | output | 64 | Registered packed result |

## Verification
The hardest case to reach is the one where a large scale meets a lane near the 32-bit extremes. There a narrower intermediate would wrap, and the clamp would choose the wrong bound without any outward sign. The bench sweeps every legal scale of every mode over a fixed set of lane patterns, including the most positive and most negative 16- and 32-bit values. It also issues directed scale-31 cases that sit at both clamp bounds. In the byte-pack sweep `status[7]` alternates, which shows that the bit outside the 4-bit field is ignored.

// File: rtl/pack_sat_pkg.sv
package pack_sat_pkg;

    localparam int WIDE_W    = 64;
    localparam int SCALE_LSB = 3;
    localparam int SCALE16_W = 4;
    localparam int SCALE32_W = 5;
    localparam int SHR_BYTE16 = 7;
    localparam int SHR_BYTE32 = 23;
    localparam int SHR_FIX    = 16;

    typedef enum logic [1:0] {
        MODE_BYTE16 = 2'b00,
        MODE_MERGE  = 2'b01,
        MODE_FIX    = 2'b10,
        MODE_RSVD   = 2'b11
    } pack_mode_e;

    typedef struct packed {
        logic              valid;
        logic [WIDE_W-1:0] data;
    } pack_out_t;

    // Scale up then renormalise at full width so no bit is lost.
    function automatic logic signed [WIDE_W-1:0] scale_shr(
        input logic signed [WIDE_W-1:0] v,
        input logic [SCALE32_W-1:0]     sc,
        input int                       shr
    );
        logic signed [WIDE_W-1:0] up;
        up = v <<< sc;
        return up >>> shr;
    endfunction

    function automatic logic [7:0] clamp_u8(input logic signed [WIDE_W-1:0] v);
        if (v < 0)
            return 8'h00;
        else if (v > 64'sd255)
            return 8'hFF;
        else
            return v[7:0];
    endfunction

    function automatic logic [15:0] clamp_s16(input logic signed [WIDE_W-1:0] v);
        if (v < -64'sd32768)
            return 16'h8000;
        else if (v > 64'sd32767)
            return 16'h7FFF;
        else
            return v[15:0];
    endfunction

endpackage

// File: rtl/pack16_lanes.sv
module pack16_lanes
    import pack_sat_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int LANE_W = 16,
    parameter int SHR    = SHR_BYTE16
) (
    input  logic [LANES*LANE_W-1:0] src,
    input  logic [SCALE16_W-1:0]    scale,
    output logic [LANES*8-1:0]      packed_o
);
    localparam int EXT_W = WIDE_W - LANE_W;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic signed [WIDE_W-1:0] ext;
        logic signed [WIDE_W-1:0] shifted;
        assign ext      = {{EXT_W{src[i*LANE_W+LANE_W-1]}}, src[i*LANE_W +: LANE_W]};
        assign shifted  = scale_shr(ext, SCALE32_W'(scale), SHR);
        assign packed_o[i*8 +: 8] = clamp_u8(shifted);
    end

endmodule

// File: rtl/pack32_merge.sv
module pack32_merge
    import pack_sat_pkg::*;
#(
    parameter int LANES  = 2,
    parameter int LANE_W = 32,
    parameter int SHR    = SHR_BYTE32
) (
    input  logic [LANES*LANE_W-1:0] src_a,
    input  logic [LANES*LANE_W-1:0] src_b,
    input  logic [SCALE32_W-1:0]    scale,
    output logic [LANES*LANE_W-1:0] merged
);
    localparam int EXT_W  = WIDE_W - LANE_W;
    localparam int KEEP_W = LANE_W - 8;

    for (genvar i = 0; i < LANES; i++) begin : g_word
        logic signed [WIDE_W-1:0] ext;
        logic signed [WIDE_W-1:0] shifted;
        logic                     unused_hi;
        assign ext     = {{EXT_W{src_b[i*LANE_W+LANE_W-1]}}, src_b[i*LANE_W +: LANE_W]};
        assign shifted = scale_shr(ext, scale, SHR);
        // The top byte of each word of A is shifted out of the word; the
        // vacated low byte of the word takes the clamped pixel.
        assign merged[i*LANE_W +: LANE_W] = {src_a[i*LANE_W +: KEEP_W], clamp_u8(shifted)};
        assign unused_hi = ^src_a[i*LANE_W+KEEP_W +: 8];
    end

endmodule

// File: rtl/packfix_lanes.sv
module packfix_lanes
    import pack_sat_pkg::*;
#(
    parameter int LANES  = 2,
    parameter int LANE_W = 32,
    parameter int SHR    = SHR_FIX
) (
    input  logic [LANES*LANE_W-1:0] src,
    input  logic [SCALE32_W-1:0]    scale,
    output logic [LANES*16-1:0]     packed_o
);
    localparam int EXT_W = WIDE_W - LANE_W;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic signed [WIDE_W-1:0] ext;
        logic signed [WIDE_W-1:0] shifted;
        assign ext      = {{EXT_W{src[i*LANE_W+LANE_W-1]}}, src[i*LANE_W +: LANE_W]};
        assign shifted  = scale_shr(ext, scale, SHR);
        assign packed_o[i*16 +: 16] = clamp_s16(shifted);
    end

endmodule

// File: rtl/pack_sat_unit.sv
module pack_sat_unit
    import pack_sat_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [1:0]  mode,
    input  logic [63:0] status,
    input  logic [63:0] opa,
    input  logic [63:0] opb,
    output logic        out_valid,
    output logic [63:0] result
);
    localparam int HALF_W = WIDE_W / 2;

    logic [SCALE16_W-1:0] scale16;
    logic [SCALE32_W-1:0] scale32;
    logic [HALF_W-1:0]    byte16_res;
    logic [WIDE_W-1:0]    merge_res;
    logic [HALF_W-1:0]    fix_res;
    pack_mode_e           mode_e;
    pack_out_t            nxt_q;
    pack_out_t            out_q;
    logic                 unused_status;

    assign scale16 = status[SCALE_LSB +: SCALE16_W];
    assign scale32 = status[SCALE_LSB +: SCALE32_W];
    assign mode_e  = pack_mode_e'(mode);
    assign unused_status = ^{status[WIDE_W-1:SCALE_LSB+SCALE32_W], status[SCALE_LSB-1:0]};

    pack16_lanes #(
        .LANES  (4),
        .LANE_W (16),
        .SHR    (SHR_BYTE16)
    ) u_byte16 (
        .src      (opb),
        .scale    (scale16),
        .packed_o (byte16_res)
    );

    pack32_merge #(
        .LANES  (2),
        .LANE_W (32),
        .SHR    (SHR_BYTE32)
    ) u_merge (
        .src_a  (opa),
        .src_b  (opb),
        .scale  (scale32),
        .merged (merge_res)
    );

    packfix_lanes #(
        .LANES  (2),
        .LANE_W (32),
        .SHR    (SHR_FIX)
    ) u_fix (
        .src      (opb),
        .scale    (scale32),
        .packed_o (fix_res)
    );

    always_comb begin
        nxt_q.valid = in_valid;
        unique case (mode_e)
            MODE_BYTE16: nxt_q.data = {{HALF_W{1'b0}}, byte16_res};
            MODE_MERGE:  nxt_q.data = merge_res;
            MODE_FIX:    nxt_q.data = {{HALF_W{1'b0}}, fix_res};
            default:     nxt_q.data = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q.valid <= nxt_q.valid;
            if (in_valid)
                out_q.data <= nxt_q.data;
        end
    end

    assign out_valid = out_q.valid;
    assign result    = out_q.data;

endmodule

// File: rtl/pack_sat_unit_chk.sv
module pack_sat_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [1:0]  mode,
    input logic [63:0] opa,
    input logic        out_valid,
    input logic [63:0] result
);

    // R1: reset is synchronous; the bench holds rst high from time zero.
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!out_valid && result == 64'h0));

    assert_valid_follow_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_idle_low_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_hi_zero_byte_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == 2'b00) |=> (result[63:32] == 32'h0));

    assert_merge_keep_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == 2'b01) |=>
            (result[31:8] == $past(opa[23:0]) && result[63:40] == $past(opa[55:32])));

    assert_hi_zero_fix_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == 2'b10) |=> (result[63:32] == 32'h0));

    assert_rsvd_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == 2'b11) |=> (result == 64'h0));

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result));

endmodule

bind pack_sat_unit pack_sat_unit_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .mode      (mode),
    .opa       (opa),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/pack_sat_unit_tb.sv
`timescale 1ns/1ps
module pack_sat_unit_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic [63:0] status = '0;
    logic [63:0] opa = '0;
    logic [63:0] opb = '0;
    logic        out_valid;
    logic [63:0] result;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    pack_sat_unit u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .mode      (mode),
        .status    (status),
        .opa       (opa),
        .opb       (opb),
        .out_valid (out_valid),
        .result    (result)
    );

    localparam logic [63:0] VEC [8] = '{
        64'h0000_0000_0000_0000,
        64'h7FFF_8000_0001_FFFF,
        64'h0080_0100_00FF_FF80,
        64'h1234_EDCC_0C00_F3A1,
        64'h0002_0003_0004_0005,
        64'hFFFF_FFFE_8001_7FFE,
        64'h4000_0040_0020_C000,
        64'h7FFF_FFFF_8000_0000
    };

    function automatic logic [63:0] ref_byte16(logic [63:0] b, int sc);
        logic [63:0] r = '0;
        for (int i = 0; i < 4; i++) begin
            longint v;
            v = longint'($signed(b[i*16 +: 16]));
            v = (v <<< sc) >>> 7;
            r[i*8 +: 8] = (v < 0) ? 8'h00 : (v > 255) ? 8'hFF : v[7:0];
        end
        return r;
    endfunction

    function automatic logic [63:0] ref_merge(logic [63:0] a, logic [63:0] b, int sc);
        logic [63:0] r;
        r = (a << 8) & ~64'h0000_00FF_0000_00FF;
        for (int w = 0; w < 2; w++) begin
            longint v;
            v = longint'($signed(b[w*32 +: 32]));
            v = (v <<< sc) >>> 23;
            r[w*32 +: 8] = (v < 0) ? 8'h00 : (v > 255) ? 8'hFF : v[7:0];
        end
        return r;
    endfunction

    function automatic logic [63:0] ref_fix(logic [63:0] b, int sc);
        logic [63:0] r = '0;
        for (int w = 0; w < 2; w++) begin
            longint v;
            v = longint'($signed(b[w*32 +: 32]));
            v = (v <<< sc) >>> 16;
            if (v < -32768) v = -32768;
            if (v > 32767)  v = 32767;
            r[w*16 +: 16] = v[15:0];
        end
        return r;
    endfunction

    task automatic check(string req, logic ok, logic [64:0] act, logic [64:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual {valid,data}=%h expected %h", req, act, exp);
        end
    endtask

    // Drive one operation at a falling edge, inspect it one falling edge later.
    task automatic run_op(logic [1:0] m, logic [63:0] st, logic [63:0] a,
                          logic [63:0] b, logic [63:0] exp, string req);
        @(negedge clk);
        mode = m; status = st; opa = a; opb = b; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(req, out_valid === 1'b1 && result === exp,
              {out_valid, result}, {1'b1, exp});
    endtask

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] held;
        // R1: state during and right after reset
        repeat (3) @(negedge clk);
        check("R1", out_valid === 1'b0 && result === 64'h0, {out_valid, result}, 65'h0);
        rst = 1'b0;
        @(negedge clk);
        check("R2 idle", out_valid === 1'b0, {out_valid, result}, {1'b0, result});

        // R3/R4: every 4-bit scale, status[7] toggled to show it is ignored
        for (int sc = 0; sc < 16; sc++) begin
            for (int v = 0; v < 8; v++) begin
                logic [63:0] st;
                st = 64'hDEAD_BEEF_0000_0000 | (64'(sc) << 3) | (64'(v & 1) << 7) | 64'(v & 7);
                run_op(2'b00, st, VEC[(v + 3) % 8], VEC[v], ref_byte16(VEC[v], sc), "R3/R4");
            end
        end

        // R5/R6: every 5-bit scale with merge
        for (int sc = 0; sc < 32; sc++) begin
            for (int v = 0; v < 8; v++) begin
                logic [63:0] st;
                st = 64'h0123_4567_89AB_0000 | (64'(sc) << 3) | 64'(v & 7);
                run_op(2'b01, st, VEC[(v + 5) % 8] ^ 64'hA5A5_5A5A_C3C3_3C3C, VEC[v],
                       ref_merge(VEC[(v + 5) % 8] ^ 64'hA5A5_5A5A_C3C3_3C3C, VEC[v], sc), "R5/R6");
            end
        end

        // R7: every 5-bit scale, fixed pack
        for (int sc = 0; sc < 32; sc++) begin
            for (int v = 0; v < 8; v++) begin
                logic [63:0] st;
                st = 64'hFFFF_0000_FFFF_0000 | (64'(sc) << 3) | 64'(v & 7);
                run_op(2'b10, st, VEC[v], VEC[v], ref_fix(VEC[v], sc), "R7");
            end
        end

        // R8: scale 31 on extreme 32-bit lanes; lane 1 = most positive, lane 0 = most negative
        run_op(2'b10, 64'hF8, 64'h0, 64'h7FFF_FFFF_8000_0000, 64'h0000_0000_7FFF_8000, "R8 fix");
        run_op(2'b01, 64'hF8, 64'h0, 64'h7FFF_FFFF_8000_0000, 64'h0000_00FF_0000_0000, "R8 merge");
        run_op(2'b10, 64'hF8, 64'h0, 64'h0000_0001_FFFF_FFFF, 64'h0000_0000_7FFF_8000, "R8 small");

        // R9: reserved mode, after a nonzero result
        run_op(2'b10, 64'h40, 64'h0, 64'h0001_0000_0002_0000, ref_fix(64'h0001_0000_0002_0000, 8), "R7 pre");
        run_op(2'b11, 64'hFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h7FFF_7FFF_7FFF_7FFF, 64'h0, "R9");

        // R10: inputs churn with in_valid low; result must hold
        run_op(2'b01, 64'h38, 64'h1122_3344_5566_7788, 64'h0100_0000_0200_0000,
               ref_merge(64'h1122_3344_5566_7788, 64'h0100_0000_0200_0000, 7), "R6 pre");
        held = ref_merge(64'h1122_3344_5566_7788, 64'h0100_0000_0200_0000, 7);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            mode = 2'(k); status = ~status; opa = ~opa; opb = VEC[k];
            check("R10", out_valid === 1'b0 && result === held, {out_valid, result}, {1'b0, held});
        end

        // R2: back-to-back operations each produce one valid cycle
        @(negedge clk);
        mode = 2'b00; status = 64'h0; opb = 64'h0000_0000_0000_7F80; in_valid = 1'b1;
        @(negedge clk);
        check("R2 b2b first", out_valid === 1'b1 && result === ref_byte16(64'h7F80, 0),
              {out_valid, result}, {1'b1, ref_byte16(64'h7F80, 0)});
        opb = 64'h0000_0000_0000_0100;
        @(negedge clk);
        in_valid = 1'b0;
        check("R2 b2b second", out_valid === 1'b1 && result === 64'h2,
              {out_valid, result}, {1'b1, 64'h2});
        @(negedge clk);
        check("R2 drop", out_valid === 1'b0, {out_valid, result}, {1'b0, result});

        // R1: mid-run reset clears state
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 mid", out_valid === 1'b0 && result === 64'h0, {out_valid, result}, 65'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule